// File: doc/BRIEF.md
# Security Code Gate

This block decides whether a memory write or erase may go ahead. It watches the commands that the command decoder issues. The storage array and the serial front end are outside the block. The block uses three reserved bytes at the top of the address space: an 8-bit attempt counter and the two bytes of a secret code.

A verification attempt has three steps in order:
- Write the counter so that at least one of its still-set bits is cleared.
- Compare the lower code byte.
- Compare the upper code byte.

If both compares match, the block unlocks. It stays unlocked until its reset, which stands for power-off. Any mismatch, or any step taken out of order, ends the attempt, and the counter bit it used is lost. When the counter reaches zero, no further attempt can start, so every write stays refused for good. Once unlocked, the counter may be erased back to all ones, but only by an explicit write.

The block also blanks reads of the two code bytes. It drives the level of the serial data line that reports the end of processing: the line falls when the array reports that processing is done and rises again on the next card-reset rise.

Top module: `seccode_gate`

## Requirements
- R1: After reset `unlocked` is 0, `wrGrant` is 0 and `ioLevel` is 1.
- R2: `rdData` is 0x00 whenever `rdAddr` is one of the two highest addresses (the code bytes). For every other address `rdData` equals `rdRaw`. The output is combinational.
- R3: While locked, an update command (`cmdOp`=2'b01) to any address other than the counter is refused: `wrGrant` is 0 in the cycle after `cmdValid`.
- R4: The counter sits at the third-highest address. While locked, an update to the counter is granted (`wrGrant`=1 in the cycle after `cmdValid`) only if all three conditions hold: the current byte (`memData`) is nonzero, the new byte sets no bit that is currently clear, and the new byte clears at least one currently set bit.
- R5: Only a granted counter update made while locked arms an attempt. Code compares made without arming never unlock.
- R6: After an attempt is armed, two compare commands (`cmdOp`=2'b10) must follow: first at the second-highest address, then at the highest address, each with `cmdData` equal to `memData`. When both match, `unlocked` rises in the cycle after the second compare. Bit 0 of `cmdData` holds the first serial bit.
- R7: Any of these ends the attempt, and a new counter bit must then be spent: a mismatching code compare, an upper-byte compare before the lower, or a repeated lower-byte compare.
- R8: Reads, and compares at addresses other than the code bytes, leave a pending attempt intact.
- R9: When the counter is zero while locked, no write is granted. This includes erasing the counter back to 0xFF. Eight failed attempts from 0xFF therefore lock the block permanently.
- R10: Once unlocked, `unlocked` stays 1 until reset. Every update is granted, including erasing the counter to 0xFF. Later failing compares do not relock the block.
- R11: A protect-write command (`cmdOp`=2'b11) is granted only while unlocked, even at the counter address.
- R12: `ioLevel` goes to 0 in the cycle after `procDone` and returns to 1 in the cycle after `rstRise`. When both arrive in the same cycle, `rstRise` wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset (power-off) |
| cmdValid | input | 1 | One-cycle command strobe |
| cmdOp | input | 2 | 00 read, 01 update, 10 compare, 11 protect-write |
| cmdAddr | input | ADDR_W | Command address |
| cmdData | input | DATA_W | New data or compare data |
| memData | input | DATA_W | Array content at `cmdAddr` |
| rdAddr | input | ADDR_W | Read-out address |
| rdRaw | input | DATA_W | Array content at `rdAddr` |
| rdData | output | DATA_W | Read-out data with code bytes blanked |
| procDone | input | 1 | Array processing finished |
| rstRise | input | 1 | Rising edge seen on the card reset line |
| wrGrant | output | 1 | Write permitted for the previous command |
| unlocked | output | 1 | Code verified since reset |
| ioLevel | output | 1 | Level of the serial data line |

## Verification
The bench builds the block with ADDR_W=4 and DATA_W=8. This places the counter at address 13 and the code bytes at 14 and 15, so every address can be swept for read blanking and write refusal. With this setting, all 256 new counter values can be tried against several current counter values and checked against the spend rule. Even a full run of eight failed attempts down to permanent lock fits in a short run.

// File: rtl/seccode_pkg.sv
package seccode_pkg;
  typedef enum logic [1:0] {
    OP_READ    = 2'b00,
    OP_UPDATE  = 2'b01,
    OP_COMPARE = 2'b10,
    OP_PROTECT = 2'b11
  } cmd_op_e;

  typedef enum logic [1:0] {
    PH_IDLE     = 2'b00,
    PH_ARMED    = 2'b01,
    PH_FIRST_OK = 2'b10
  } phase_e;

  // datapath to control: decoded facts about the current command
  typedef struct packed {
    logic atCounter;
    logic atCode1;
    logic atCode2;
    logic byteMatch;
    logic ecSpendOk;
  } dp_flags_t;

  // control to datapath: strobes
  typedef struct packed {
    logic grant;
  } ctrl_strobe_t;
endpackage

// File: rtl/seccode_dp.sv
module seccode_dp
  import seccode_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [DATA_W-1:0] memData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdRaw,
  output logic [DATA_W-1:0] rdData,
  output dp_flags_t         flags,
  input  ctrl_strobe_t      strobe,
  input  logic              unlocked,
  output logic              wrGrant
);
  localparam int unsigned TOP_ADDR = (1 << ADDR_W) - 1;
  localparam logic [ADDR_W-1:0] CODE2_ADDR = ADDR_W'(TOP_ADDR);
  localparam logic [ADDR_W-1:0] CODE1_ADDR = ADDR_W'(TOP_ADDR - 1);
  localparam logic [ADDR_W-1:0] EC_ADDR    = ADDR_W'(TOP_ADDR - 2);

  logic setsBits;
  logic clearsBits;
  logic rdIsCode;

  always_comb begin
    setsBits        = |(~memData & cmdData);
    clearsBits      = |(memData & ~cmdData);
    flags.atCounter = (cmdAddr == EC_ADDR);
    flags.atCode1   = (cmdAddr == CODE1_ADDR);
    flags.atCode2   = (cmdAddr == CODE2_ADDR);
    flags.byteMatch = (cmdData == memData);
    flags.ecSpendOk = (|memData) && !setsBits && clearsBits;
  end

  always_comb begin
    rdIsCode = (rdAddr == CODE1_ADDR) || (rdAddr == CODE2_ADDR);
    rdData   = rdIsCode ? '0 : rdRaw;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrGrant <= 1'b0;
    else       wrGrant <= strobe.grant;
  end

  // a grant while locked can only follow a command aimed at the counter
  assert_locked_grant_only_counter_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrGrant |-> ($past(unlocked) || $past(flags.atCounter)));
endmodule

// File: rtl/seccode_ctrl.sv
module seccode_ctrl
  import seccode_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic [1:0]   cmdOp,
  input  dp_flags_t    flags,
  input  logic         procDone,
  input  logic         rstRise,
  output ctrl_strobe_t strobe,
  output logic         unlocked,
  output logic         ioLevel
);
  phase_e phase, phaseNext;
  logic   unlockNext;
  logic   isWrite;
  logic   isCompare;

  always_comb begin
    isWrite   = cmdValid && ((cmdOp == OP_UPDATE) || (cmdOp == OP_PROTECT));
    isCompare = cmdValid && (cmdOp == OP_COMPARE);
    strobe.grant = isWrite &&
      (unlocked || ((cmdOp == OP_UPDATE) && flags.atCounter && flags.ecSpendOk));
  end

  always_comb begin
    phaseNext  = phase;
    unlockNext = unlocked;
    if (cmdValid && !unlocked) begin
      if (strobe.grant && flags.atCounter) begin
        phaseNext = PH_ARMED;
      end else if (isCompare && flags.atCode1) begin
        phaseNext = (phase == PH_ARMED && flags.byteMatch) ? PH_FIRST_OK : PH_IDLE;
      end else if (isCompare && flags.atCode2) begin
        phaseNext = PH_IDLE;
        if (phase == PH_FIRST_OK && flags.byteMatch) unlockNext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      unlocked <= 1'b0;
      ioLevel  <= 1'b1;
    end else begin
      phase    <= phaseNext;
      unlocked <= unlockNext;
      if (rstRise)       ioLevel <= 1'b1;
      else if (procDone) ioLevel <= 1'b0;
    end
  end

  assert_unlock_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    unlocked |=> unlocked);

  assert_unlock_after_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> ($past(phase) == PH_FIRST_OK));

  assert_first_from_armed_R7: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_FIRST_OK && $past(phase) != PH_FIRST_OK) |-> ($past(phase) == PH_ARMED));

  assert_io_rise_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ioLevel) |-> $past(rstRise));

  assert_io_fall_R12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ioLevel) |-> $past(procDone));
endmodule

// File: rtl/seccode_gate.sv
module seccode_gate
  import seccode_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [DATA_W-1:0] memData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdRaw,
  output logic [DATA_W-1:0] rdData,
  input  logic              procDone,
  input  logic              rstRise,
  output logic              wrGrant,
  output logic              unlocked,
  output logic              ioLevel
);
  dp_flags_t    flags;
  ctrl_strobe_t strobe;

  seccode_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .memData(memData), .rdAddr(rdAddr), .rdRaw(rdRaw), .rdData(rdData),
    .flags(flags), .strobe(strobe), .unlocked(unlocked), .wrGrant(wrGrant)
  );

  seccode_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .flags(flags), .procDone(procDone), .rstRise(rstRise),
    .strobe(strobe), .unlocked(unlocked), .ioLevel(ioLevel)
  );
endmodule

// File: tb/seccode_gate_bench.sv
module seccode_gate_bench;
  localparam int AW = 4;
  localparam int EC = 13;
  localparam int C1 = 14;
  localparam int C2 = 15;
  localparam logic [7:0] K1 = 8'h5A;
  localparam logic [7:0] K2 = 8'hC3;

  logic clk = 0, rstN = 0, cmdValid = 0, procDone = 0, rstRise = 0;
  logic [1:0] cmdOp = 0;
  logic [AW-1:0] cmdAddr = 0, rdAddr = 0;
  logic [7:0] cmdData = 0, memData, rdRaw = 0, rdData;
  logic wrGrant, unlocked, ioLevel;
  logic [7:0] mem [16];
  int checks = 0, fails = 0;

  assign memData = mem[cmdAddr];

  seccode_gate #(.ADDR_W(AW), .DATA_W(8)) u_seccode_gate (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .memData(memData), .rdAddr(rdAddr), .rdRaw(rdRaw),
    .rdData(rdData), .procDone(procDone), .rstRise(rstRise), .wrGrant(wrGrant),
    .unlocked(unlocked), .ioLevel(ioLevel)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input int addr, input int data,
                     input bit apply, output bit g);
    @(negedge clk);
    cmdValid = 1; cmdOp = op; cmdAddr = AW'(addr); cmdData = 8'(data);
    @(negedge clk);
    cmdValid = 0;
    g = wrGrant;
    if (apply && g) mem[addr] = 8'(data);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  function automatic bit spendOk(input logic [7:0] o, input logic [7:0] n);
    return (o != 0) && ((~o & n) == 0) && ((o & ~n) != 0);
  endfunction

  // spend the lowest set counter bit
  task automatic arm(input string req);
    bit g;
    logic [7:0] o;
    o = mem[EC];
    cmd(2'b01, EC, o & (o - 8'd1), 1, g);
    check(g == 1, req, g, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit g;
    for (int i = 0; i < 16; i++) mem[i] = 8'(i * 17 + 3);
    mem[EC] = 8'hFF; mem[C1] = K1; mem[C2] = K2;
    doReset();
    @(negedge clk);
    check(unlocked == 0, "R1 unlocked", unlocked, 0);
    check(wrGrant == 0, "R1 wrGrant", wrGrant, 0);
    check(ioLevel == 1, "R1 ioLevel", ioLevel, 1);

    // R2 read blanking sweep
    for (int a = 0; a < 16; a++) begin
      rdAddr = AW'(a); rdRaw = 8'(a * 37 + 5);
      #1;
      check(rdData == ((a >= C1) ? 8'h00 : 8'(a * 37 + 5)), "R2 read mask", rdData,
            (a >= C1) ? 0 : (a * 37 + 5) & 255);
    end

    // R3 non-counter writes refused while locked
    for (int a = 0; a < 16; a++) begin
      if (a == EC) continue;
      cmd(2'b01, a, 8'h00, 0, g);
      check(g == 0, "R3 locked write", g, 0);
    end

    // R4 counter spend rule sweep
    foreach (mem[k]) begin end
    for (int s = 0; s < 6; s++) begin
      logic [7:0] olds [6] = '{8'hFF, 8'h80, 8'h01, 8'h00, 8'hA5, 8'h7E};
      mem[EC] = olds[s];
      for (int n = 0; n < 256; n++) begin
        cmd(2'b01, EC, n, 0, g);
        check(g == spendOk(olds[s], 8'(n)), "R4 counter spend", g, spendOk(olds[s], 8'(n)));
      end
    end

    // R11 protect-write refused while locked, even at counter
    mem[EC] = 8'hFF;
    cmd(2'b11, EC, 8'hFE, 0, g);
    check(g == 0, "R11 protect locked", g, 0);

    // R5 compares without arming
    doReset();
    mem[EC] = 8'hFF;
    cmd(2'b10, C1, K1, 0, g);
    cmd(2'b10, C2, K2, 0, g);
    check(unlocked == 0, "R5 no arm", unlocked, 0);

    // R7 mismatch on lower byte
    arm("R4 arm grant");
    cmd(2'b10, C1, K1 ^ 8'h01, 0, g);
    cmd(2'b10, C2, K2, 0, g);
    check(unlocked == 0, "R7 lower mismatch", unlocked, 0);
    cmd(2'b10, C1, K1, 0, g);
    cmd(2'b10, C2, K2, 0, g);
    check(unlocked == 0, "R7 attempt ended", unlocked, 0);
    // upper before lower
    arm("R4 arm grant");
    cmd(2'b10, C2, K2, 0, g);
    cmd(2'b10, C1, K1, 0, g);
    cmd(2'b10, C2, K2, 0, g);
    check(unlocked == 0, "R7 order", unlocked, 0);
    // repeated lower
    arm("R4 arm grant");
    cmd(2'b10, C1, K1, 0, g);
    cmd(2'b10, C1, K1, 0, g);
    cmd(2'b10, C2, K2, 0, g);
    check(unlocked == 0, "R7 repeat lower", unlocked, 0);
    // upper mismatch
    arm("R4 arm grant");
    cmd(2'b10, C1, K1, 0, g);
    cmd(2'b10, C2, K2 ^ 8'h80, 0, g);
    check(unlocked == 0, "R7 upper mismatch", unlocked, 0);

    // R9 spend the rest down to zero
    for (int t = 0; t < 4; t++) begin
      arm("R9 arm grant");
      cmd(2'b10, C1, 8'h00, 0, g);
    end
    check(mem[EC] == 8'h00, "R9 counter empty", mem[EC], 0);
    cmd(2'b01, EC, 8'hFF, 1, g);
    check(g == 0, "R9 erase refused", g, 0);
    cmd(2'b01, EC, 8'h00, 1, g);
    check(g == 0, "R9 write refused", g, 0);
    cmd(2'b01, 2, 8'h11, 1, g);
    check(g == 0, "R9 data write refused", g, 0);
    cmd(2'b10, C1, K1, 0, g);
    cmd(2'b10, C2, K2, 0, g);
    check(unlocked == 0, "R9 locked out", unlocked, 0);

    // R6 plain success after fresh start
    doReset();
    mem[EC] = 8'hFF;
    arm("R6 arm grant");
    cmd(2'b10, C1, K1, 0, g);
    check(unlocked == 0, "R6 after lower", unlocked, 0);
    cmd(2'b10, C2, K2, 0, g);
    check(unlocked == 1, "R6 unlock", unlocked, 1);

    // R10 all writes granted once unlocked
    for (int a = 0; a < 16; a++) begin
      cmd(2'b01, a, 8'h3C, 0, g);
      check(g == 1, "R10 write granted", g, 1);
    end
    cmd(2'b01, EC, 8'hFF, 1, g);
    check(g == 1 && mem[EC] == 8'hFF, "R10 counter restore", g, 1);
    cmd(2'b10, C1, 8'h00, 0, g);
    cmd(2'b10, C2, 8'h00, 0, g);
    check(unlocked == 1, "R10 sticky", unlocked, 1);
    cmd(2'b11, 2, 8'h00, 0, g);
    check(g == 1, "R11 protect unlocked", g, 1);

    // R8 unrelated traffic during an attempt
    doReset();
    check(unlocked == 0, "R1 after reset", unlocked, 0);
    arm("R8 arm grant");
    cmd(2'b00, 2, 8'h00, 0, g);
    cmd(2'b10, 5, 8'h77, 0, g);
    cmd(2'b10, C1, K1, 0, g);
    cmd(2'b10, 3, 8'h01, 0, g);
    cmd(2'b00, C2, 8'h00, 0, g);
    cmd(2'b10, C2, K2, 0, g);
    check(unlocked == 1, "R8 attempt survives", unlocked, 1);

    // R12 io line
    @(negedge clk);
    check(ioLevel == 1, "R12 idle high", ioLevel, 1);
    procDone = 1; @(negedge clk); procDone = 0;
    check(ioLevel == 0, "R12 fall", ioLevel, 0);
    repeat (2) @(negedge clk);
    check(ioLevel == 0, "R12 hold low", ioLevel, 0);
    rstRise = 1; @(negedge clk); rstRise = 0;
    check(ioLevel == 1, "R12 rise", ioLevel, 1);
    procDone = 1; @(negedge clk); procDone = 0;
    check(ioLevel == 0, "R12 fall again", ioLevel, 0);
    procDone = 1; rstRise = 1; @(negedge clk); procDone = 0; rstRise = 0;
    check(ioLevel == 1, "R12 rise wins", ioLevel, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule